// File: doc/BRIEF.md
# Serial Memory Command Slave

This block sits between a four-wire serial host link and a byte-wide memory of 128K locations. It runs on a fast local clock, samples the serial pins through synchronizers, and turns each chip-select-framed transaction into actions on a simple parallel memory port. Every transaction starts with an 8-bit command. The command may be followed by a 17-bit address and a stream of data bytes, or by one status byte. Read data is shifted back on the serial output.

A small status register holds the write-enable latch, a two-bit region guard, a protect-enable bit and a ready indication. Writes are gated in three layers. The write-enable latch gates every write. The region guard masks the upper quarter, the upper half or the whole array from memory writes. The protect-enable bit, combined with a low level on the write-protect pin, freezes the status register. Reads and writes stream through consecutive addresses for as long as chip select stays low.

Top module: `nvspi_slave`

## Requirements
- R1: A transaction begins when chip select falls. The first 8 bits form the command, most significant bit first. The command codes are 0x06 (set write enable), 0x04 (clear write enable), 0x05 (read status), 0x01 (write status), 0x03 (read memory) and 0x02 (write memory). Any other code is ignored for the rest of the transaction.
- R2: Input bits are taken on rising serial-clock edges. Output bits change on falling edges. The host may idle the serial clock low (mode 0) or high (mode 3), and both give the same results.
- R3: After a read or write command come three address bytes, most significant bit first. Only the low 17 bits select the location; the upper 7 bits are don't-care.
- R4: Each further byte of a read or write uses the next address, with no new command. After 0x1FFFF the address wraps to 0x00000.
- R5: On a read, the first data bit appears after the falling edge that follows the last address bit. Input bits received after the address have no effect on the data returned.
- R6: Memory writes and status writes take effect only while the write-enable latch is 1. The clear command resets the latch. The latch also clears when chip select rises after a write that moved at least one full data byte, and after a full status-write byte.
- R7: Status bits 3:2 form the region guard. 00 guards nothing, 01 guards 0x18000–0x1FFFF, 10 guards 0x10000–0x1FFFF and 11 guards the whole array. A write to a guarded location never reaches the memory port, but the burst address still advances.
- R8: When status bit 7 is 1 and the write-protect pin is low, status writes are refused. Memory writes are not affected by the pin.
- R9: Status byte layout: bit 7 is protect-enable, bits 3:2 are the region guard, bit 1 is write enable, and bit 0 is busy, which reads 0 (ready). Bits 6:4 read 0. A status read keeps returning the current status for as many bytes as the host clocks.
- R10: If chip select rises partway through a byte, that byte is discarded. The serial output enable is low whenever chip select is high or no read data is being sent.
- R11: After reset, write enable, the region guard and protect-enable are 0, the serial output is disabled, and neither memory strobe is active. The two strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_wp_n | input | 1 | Active-low write-protect pin |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for the serial data pad |
| mem_addr | output | ADDR_W | Memory location for a read or write strobe |
| mem_wdata | output | 8 | Byte to be written |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe; data is expected on the next cycle |
| mem_rdata | input | 8 | Byte returned by the memory one cycle after the read strobe |

## Verification
The assertions check on every cycle that a write strobe never appears without the write-enable latch or inside the guarded region. They also check that the status guard bits never move while writes are locked, that the output enable stays low once chip select is high, and that the two strobes never overlap. The bench scenarios cover what only a full transaction shows: bit ordering, decoding of the address bytes, burst stepping and wrap-around, ignored input during reads, equal results in both clock modes, automatic clearing of write enable, and dropping of a cut-off byte.

// File: rtl/nvspi_pkg.sv
package nvspi_pkg;

  localparam logic [7:0] CMD_WRSR  = 8'h01;
  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_WRDI  = 8'h04;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_WDATA, PH_RDATA, PH_SWR, PH_SRD, PH_SKIP
  } phase_t;

  // Region guard lookup from the two top address bits.
  function automatic logic guard_hit(input logic [1:0] guard, input logic [1:0] top2);
    case (guard)
      2'b00:   return 1'b0;
      2'b01:   return (top2 == 2'b11);
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] status_pack(input logic prot_en, input logic [1:0] guard,
                                             input logic wen);
    return {prot_en, 3'b000, guard, wen, 1'b0};
  endfunction

  function automatic logic status_locked(input logic prot_en, input logic wp_n);
    return prot_en & ~wp_n;
  endfunction

endpackage

// File: rtl/nvspi_sync.sv
module nvspi_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;
  localparam logic [CHAIN_W-1:0] CHAIN_RST = {STAGES{RST_VAL}};

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= CHAIN_RST;
    else        chain <= {chain[CHAIN_W-W-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: W];

endmodule

// File: rtl/nvspi_status.sv
module nvspi_status
  import nvspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wen_set,
  input  logic       wen_clr,
  input  logic       wr_req,
  input  logic [7:0] wr_byte,
  input  logic       wp_n,
  output logic [7:0] status,
  output logic       wen,
  output logic [1:0] guard
);
  logic prot_en_q;
  logic wr_ok;

  assign wr_ok = wr_req && wen && !status_locked(prot_en_q, wp_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen       <= 1'b0;
      guard     <= 2'b00;
      prot_en_q <= 1'b0;
    end else begin
      if (wen_clr)      wen <= 1'b0;
      else if (wen_set) wen <= 1'b1;
      if (wr_ok) begin
        prot_en_q <= wr_byte[7];
        guard     <= wr_byte[3:2];
      end
    end
  end

  assign status = status_pack(prot_en_q, guard, wen);

  // Status contents move only when write enable was set beforehand.
  assert_status_needs_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({prot_en_q, guard}) |-> $past(wen));

  // A locked status register ignores write requests.
  assert_status_hw_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && prot_en_q && !wp_n) |=> $stable({prot_en_q, guard}));

endmodule

// File: rtl/nvspi_tx.sv
module nvspi_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       active,
  input  logic       fall,
  input  logic [7:0] hold,
  output logic       so,
  output logic       so_oe
);
  logic [2:0] obit;
  logic [6:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obit  <= 3'd0;
      sh    <= 7'd0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (clear) begin
      obit  <= 3'd0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (active && fall) begin
      so_oe <= 1'b1;
      obit  <= obit + 3'd1;
      if (obit == 3'd0) {so, sh} <= hold;
      else              {so, sh} <= {sh, 1'b0};
    end
  end

  // The output is only switched on from a read phase.
  assert_oe_from_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(active));

endmodule

// File: rtl/nvspi_slave.sv
module nvspi_slave
  import nvspi_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int ADDR_BYTES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_wp_n,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata
);
  localparam int AB_W = $clog2(ADDR_BYTES + 1);
  localparam logic [AB_W-1:0] AB_LAST = AB_W'(ADDR_BYTES - 1);

  // Pin synchronizers: {wp_n, si, cs_n, sck}
  logic [3:0] pin_q;
  nvspi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_wp_n, spi_si, spi_cs_n, spi_sck}),
    .q(pin_q)
  );

  logic sck_s, cs_hi, si_s, wp_s, sck_d;
  assign sck_s = pin_q[0];
  assign cs_hi = pin_q[1];
  assign si_s  = pin_q[2];
  assign wp_s  = pin_q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  // Named events for the checks
  logic sck_rise, sck_fall, byte_done;
  logic [2:0] bitn;
  logic [6:0] rx;
  logic [7:0] byte_in;
  assign sck_rise  = !cs_hi && sck_s && !sck_d;
  assign sck_fall  = !cs_hi && !sck_s && sck_d;
  assign byte_done = sck_rise && (bitn == 3'd7);
  assign byte_in   = {rx, si_s};

  // Status register
  logic       wen_set_q, wen_clr_q, sr_wr_q;
  logic [7:0] sr_byte_q, status;
  logic       wen;
  logic [1:0] guard;

  nvspi_status u_status (
    .clk(clk), .rst_n(rst_n),
    .wen_set(wen_set_q), .wen_clr(wen_clr_q),
    .wr_req(sr_wr_q), .wr_byte(sr_byte_q), .wp_n(wp_s),
    .status(status), .wen(wen), .guard(guard)
  );

  // Command sequencer
  phase_t            phase;
  logic              rd_cmd, pend_clr, rd_pend;
  logic [AB_W-1:0]   abyte;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addr_in;
  logic [ADDR_W-1:0] addr_nx;
  logic [7:0]        hold;
  logic              wr_allowed;

  assign addr_in    = {addr[ADDR_W-2:0], si_s};
  assign addr_nx    = addr + 1'b1;
  assign wr_allowed = wen && !guard_hit(guard, addr[ADDR_W-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      rd_cmd    <= 1'b0;
      pend_clr  <= 1'b0;
      rd_pend   <= 1'b0;
      abyte     <= '0;
      addr      <= '0;
      hold      <= 8'd0;
      bitn      <= 3'd0;
      rx        <= 7'd0;
      mem_addr  <= '0;
      mem_wdata <= 8'd0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      wen_set_q <= 1'b0;
      wen_clr_q <= 1'b0;
      sr_wr_q   <= 1'b0;
      sr_byte_q <= 8'd0;
    end else begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      wen_set_q <= 1'b0;
      wen_clr_q <= 1'b0;
      sr_wr_q   <= 1'b0;
      rd_pend   <= mem_re;
      if (rd_pend) hold <= mem_rdata;

      if (cs_hi) begin
        phase <= PH_CMD;
        bitn  <= 3'd0;
        abyte <= '0;
        if (pend_clr) wen_clr_q <= 1'b1;
        pend_clr <= 1'b0;
      end else if (sck_rise) begin
        rx   <= byte_in[6:0];
        bitn <= bitn + 3'd1;
        if (phase == PH_ADDR) addr <= addr_in;
        if (byte_done) begin
          case (phase)
            PH_CMD: begin
              case (byte_in)
                CMD_WREN:  begin wen_set_q <= 1'b1; phase <= PH_SKIP; end
                CMD_WRDI:  begin wen_clr_q <= 1'b1; phase <= PH_SKIP; end
                CMD_RDSR:  begin hold <= status; phase <= PH_SRD; end
                CMD_WRSR:  phase <= PH_SWR;
                CMD_READ:  begin rd_cmd <= 1'b1; phase <= PH_ADDR; end
                CMD_WRITE: begin rd_cmd <= 1'b0; phase <= PH_ADDR; end
                default:   phase <= PH_SKIP;
              endcase
            end
            PH_ADDR: begin
              abyte <= abyte + 1'b1;
              if (abyte == AB_LAST) begin
                if (rd_cmd) begin
                  mem_addr <= addr_in;
                  mem_re   <= 1'b1;
                  phase    <= PH_RDATA;
                end else begin
                  phase <= PH_WDATA;
                end
              end
            end
            PH_WDATA: begin
              pend_clr <= 1'b1;
              if (wr_allowed) begin
                mem_we    <= 1'b1;
                mem_addr  <= addr;
                mem_wdata <= byte_in;
              end
              addr <= addr_nx;
            end
            PH_RDATA: begin
              addr     <= addr_nx;
              mem_addr <= addr_nx;
              mem_re   <= 1'b1;
            end
            PH_SWR: begin
              sr_wr_q   <= 1'b1;
              sr_byte_q <= byte_in;
              pend_clr  <= 1'b1;
              phase     <= PH_SKIP;
            end
            PH_SRD:  hold <= status;
            default: ;
          endcase
        end
      end
    end
  end

  // Serial output path
  logic tx_active;
  assign tx_active = (phase == PH_RDATA) || (phase == PH_SRD);

  nvspi_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .clear(cs_hi), .active(tx_active), .fall(sck_fall),
    .hold(hold), .so(spi_so), .so_oe(spi_so_oe)
  );

  assert_we_needs_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wen);

  assert_we_outside_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !guard_hit(guard, mem_addr[ADDR_W-1 -: 2]));

  assert_so_off_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && $past(cs_hi)) |-> !spi_so_oe);

  assert_no_dual_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

endmodule

// File: tb/sim_nvspi_slave.sv
module sim_nvspi_slave;
  localparam int HP = 8;
  localparam logic [7:0] C_WRSR = 8'h01, C_WRITE = 8'h02, C_READ = 8'h03;
  localparam logic [7:0] C_WRDI = 8'h04, C_RDSR = 8'h05, C_WREN = 8'h06;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b1, wp_n = 1'b1;
  logic so, so_oe, mem_we, mem_re;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic mode3 = 1'b0;

  int checks = 0;
  int failures = 0;

  logic [7:0] bmem [int unsigned];
  logic [7:0] wb [8];
  logic [7:0] rd [8];

  nvspi_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_wp_n(wp_n), .spi_so(so), .spi_so_oe(so_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] peek(input int unsigned a);
    return bmem.exists(a) ? bmem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= peek(int'(mem_addr));
    if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rxb);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i];
      tick(HP);
      rxb[i] = so;
      sck = 1'b1;
      tick(HP);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      sck = 1'b0; si = tx[i];
      tick(HP);
      sck = 1'b1;
      tick(HP);
    end
  endtask

  task automatic t_begin();
    sck = mode3; tick(2);
    cs_n = 1'b0; tick(HP);
  endtask

  task automatic t_end();
    if (!mode3) begin sck = 1'b0; tick(HP); end
    cs_n = 1'b1; tick(3 * HP);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    t_begin(); xfer(op, d); t_end();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    t_begin(); xfer(C_RDSR, d); xfer(8'h00, v); t_end();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    t_begin(); xfer(C_WRSR, d); xfer(v, d); t_end();
  endtask

  task automatic mwrite(input logic [23:0] a, input int n);
    logic [7:0] d;
    t_begin();
    xfer(C_WRITE, d); xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < n; k++) xfer(wb[k], d);
    t_end();
  endtask

  task automatic mread(input logic [23:0] a, input int n, input logic [7:0] dummy);
    logic [7:0] d;
    t_begin();
    xfer(C_READ, d); xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < n; k++) begin xfer(dummy, d); rd[k] = d; end
    t_end();
  endtask

  task automatic test_reset();
    logic [7:0] s;
    chk("R11 oe after reset", so_oe, 0);
    chk("R11 strobes after reset", {mem_we, mem_re}, 0);
    rdsr(s);
    chk("R11 R9 status after reset", s, 8'h00);
  endtask

  task automatic test_wen();
    logic [7:0] s;
    cmd(C_WREN); rdsr(s);
    chk("R1 R9 set write enable", s, 8'h02);
    cmd(C_WRDI); rdsr(s);
    chk("R6 clear write enable", s, 8'h00);
    cmd(C_WREN); cmd(8'hAB); rdsr(s);
    chk("R1 unknown command ignored", s, 8'h02);
    cmd(C_WRDI);
  endtask

  task automatic test_burst_rw();
    logic [7:0] s;
    cmd(C_WREN);
    wb[0] = 8'hA5; wb[1] = 8'h3C; wb[2] = 8'h7E;
    mwrite(24'h000100, 3);
    chk("R4 burst byte0", peek(32'h100), 8'hA5);
    chk("R4 burst byte1", peek(32'h101), 8'h3C);
    chk("R4 burst byte2", peek(32'h102), 8'h7E);
    rdsr(s);
    chk("R6 auto clear after write", s, 8'h00);
    mread(24'h000100, 3, 8'hFF);
    chk("R3 R5 read byte0", rd[0], 8'hA5);
    chk("R4 R5 read byte1", rd[1], 8'h3C);
    chk("R4 R5 read byte2", rd[2], 8'h7E);
    mread(24'h000101, 1, 8'h00);
    chk("R5 dummy input no effect", rd[0], 8'h3C);
  endtask

  task automatic test_mode3();
    mode3 = 1'b1;
    mread(24'h000100, 2, 8'h00);
    chk("R2 mode3 read byte0", rd[0], 8'hA5);
    chk("R2 mode3 read byte1", rd[1], 8'h3C);
    cmd(C_WREN);
    wb[0] = 8'h5D; mwrite(24'h000180, 1);
    chk("R2 mode3 write", peek(32'h180), 8'h5D);
    mode3 = 1'b0;
  endtask

  task automatic test_no_wen();
    wb[0] = 8'h11; mwrite(24'h000200, 1);
    chk("R6 write without enable", peek(32'h200), 8'h00);
  endtask

  task automatic test_wrap();
    cmd(C_WREN);
    wb[0] = 8'hC1; wb[1] = 8'hC2;
    mwrite(24'hFFFFFF, 2);
    chk("R3 upper address bits ignored", peek(32'h1FFFF), 8'hC1);
    chk("R4 wrap to zero", peek(32'h0), 8'hC2);
    mread(24'h01FFFF, 2, 8'h00);
    chk("R4 read wrap byte0", rd[0], 8'hC1);
    chk("R4 read wrap byte1", rd[1], 8'hC2);
  endtask

  task automatic test_partial();
    logic [7:0] s;
    logic [7:0] d;
    cmd(C_WREN);
    t_begin();
    xfer(C_WRITE, d); xfer(8'h00, d); xfer(8'h03, d); xfer(8'h00, d);
    chk("R10 oe low during write", so_oe, 0);
    xfer_bits(8'hFF, 5);
    t_end();
    chk("R10 partial byte dropped", peek(32'h300), 8'h00);
    rdsr(s);
    chk("R10 no completed byte keeps enable", s, 8'h02);
    chk("R10 oe low after cs high", so_oe, 0);
    cmd(C_WRDI);
  endtask

  task automatic test_guard();
    logic [7:0] s;
    logic [7:0] d;
    cmd(C_WREN); wrsr(8'h04); rdsr(s);
    chk("R7 R9 guard quarter set", s, 8'h04);
    cmd(C_WREN);
    wb[0] = 8'hD1; wb[1] = 8'hD2; mwrite(24'h017FFF, 2);
    chk("R7 below quarter written", peek(32'h17FFF), 8'hD1);
    chk("R7 quarter blocked", peek(32'h18000), 8'h00);
    cmd(C_WREN); wrsr(8'h08);
    cmd(C_WREN);
    wb[0] = 8'hE1; wb[1] = 8'hE2; mwrite(24'h00FFFF, 2);
    chk("R7 below half written", peek(32'h0FFFF), 8'hE1);
    chk("R7 half blocked", peek(32'h10000), 8'h00);
    cmd(C_WREN); wrsr(8'h0C);
    cmd(C_WREN);
    wb[0] = 8'hF1; mwrite(24'h000005, 1);
    chk("R7 whole array blocked", peek(32'h5), 8'h00);
    wrsr(8'h00); rdsr(s);
    chk("R6 status write needs enable", s, 8'h0C);
    cmd(C_WREN); wrsr(8'h70); rdsr(s);
    chk("R9 unused bits read zero", s, 8'h00);
    t_begin(); xfer(C_RDSR, d); xfer(8'h00, d); xfer(8'h00, s); t_end();
    chk("R9 repeated status byte", s, 8'h00);
  endtask

  task automatic test_hw();
    logic [7:0] s;
    cmd(C_WREN); wrsr(8'h80); rdsr(s);
    chk("R8 protect enable set", s, 8'h80);
    wp_n = 1'b0;
    cmd(C_WREN); wrsr(8'h8C); rdsr(s);
    chk("R8 status locked by pin", s, 8'h80);
    cmd(C_WREN);
    wb[0] = 8'h9A; mwrite(24'h000400, 1);
    chk("R8 memory write not locked", peek(32'h400), 8'h9A);
    wp_n = 1'b1;
    cmd(C_WREN); wrsr(8'h00); rdsr(s);
    chk("R8 unlocked after pin high", s, 8'h00);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    test_reset();
    test_wen();
    test_burst_rw();
    test_mode3();
    test_no_wen();
    test_wrap();
    test_partial();
    test_guard();
    test_hw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule